// File: doc/BRIEF.md
# Lock-Aware Thread Scheduler

This block picks which of four hardware threads issues next into a single-issue, in-order, five-stage pipeline. In every cycle it looks at each thread. A thread can be chosen only if it is ready, is not parked waiting on a lock, and is not held back by the hazard gap that its previous instruction declared. From the threads that pass, it takes the first one at or after a rotating pointer.

The hazard gap is fixed at compile time and travels with each instruction as a 2-bit field. The pipeline therefore needs no dynamic hazard comparator when fewer than four threads are runnable. If a thread issues a lock-acquire instruction and the lock unit refuses it in the following cycle, the thread is parked. It stays parked until the lock unit sends a wake pulse for it. The same instruction then issues again.

The choice is combinational from the current state and inputs, so selection adds no pipeline stage. When no thread qualifies, the block emits a bubble.

Top module: `lock_aware_sched`

## Requirements
- R1: While reset is asserted, issueValid is low. After reset, every thread is eligible and the rotation starts at thread 0, so with all threads ready the issue order is 0, 1, 2, 3, 0.
- R2: issueValid is high exactly when at least one thread is eligible. When no thread is eligible, a bubble is emitted with issueValid low.
- R3: The search starts at the thread after the last one issued and goes upward in index, wrapping from 3 to 0. The pointer does not move on a bubble.
- R4: A thread that issues an instruction with hazard distance d is not selected in the next d cycles and is selectable again in cycle d+1. Thread t's distance is hazDist[2t+1:2t], with values 0, 1 or 2.
- R5: A thread whose threadReady bit is low is never selected.
- R6: A thread that issues with its lockReq bit high is not selected in the next cycle. lockGrant is sampled in that cycle. If lockGrant is high there, the thread is eligible again from the cycle after. Other threads may issue while the lock answer is pending.
- R7: If lockGrant is low in the answer cycle, the thread is parked. It is not selected until a cycle in which its wake bit is high. It becomes selectable in the cycle after that pulse, where it replays.
- R8: If the lock refusal and a wake pulse for the same thread fall in the same cycle, the wake wins. The thread is not parked and is selectable in the next cycle.
- R9: A single runnable thread issuing instructions with distances 0, 1, 0, 0 issues them in cycles 0, 1, 3 and 4.
- R10: Selection is combinational. A change on threadReady is reflected on issueValid and issueTid in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| threadReady | input | 4 | Per-thread ready flag, bit t for thread t |
| hazDist | input | 8 | Per-thread hazard distance of the head instruction, 2 bits per thread |
| lockReq | input | 4 | Per-thread flag: the head instruction is a lock acquire |
| lockGrant | input | 1 | Lock unit answer, sampled in the cycle after a lock acquire issues |
| wake | input | 4 | Per-thread unlock pulse that releases a parked thread |
| issueValid | output | 1 | A thread is issued this cycle |
| issueTid | output | 2 | Index of the issued thread |

## Verification
Two functions can fall in the same cycle. One is the lock unit refusing a thread's lock acquire. The other is an unlock pulse for that same thread. The stimulus issues a lock acquire from a lone ready thread, then holds lockGrant low and raises that thread's wake bit in the answer cycle. The result is judged by whether the thread issues in the very next cycle, which is the only outcome when the wake takes priority. A second overlap has one thread waiting on its lock answer while another thread is ready. That case is judged by the second thread issuing in the pending cycle and the first one issuing after it.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int THREADS = 4;
  localparam int TID_W   = $clog2(THREADS);
  localparam int HAZ_W   = 2;

  typedef logic [TID_W-1:0] tid_t;

  // strobe from the picker to the per-thread state
  typedef struct packed {
    logic fire;
    tid_t tid;
  } issue_strobe_t;
endpackage

// File: rtl/sched_state.sv
module sched_state
  import sched_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [THREADS-1:0]        threadReady,
  input  logic [THREADS*HAZ_W-1:0]  hazDist,
  input  logic [THREADS-1:0]        lockReq,
  input  logic                      lockGrant,
  input  logic [THREADS-1:0]        wake,
  input  issue_strobe_t             strobe,
  output logic [THREADS-1:0]        elig
);
  logic pendValid;
  tid_t pendTid;

  // one outstanding lock answer at most: it arrives the cycle after issue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendTid   <= '0;
    end else begin
      pendValid <= strobe.fire && lockReq[strobe.tid];
      pendTid   <= strobe.tid;
    end
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [HAZ_W-1:0] hazCnt;
    logic             parked;
    logic             issuedHere;
    logic             answerHere;

    assign issuedHere = strobe.fire && (strobe.tid == tid_t'(t));
    assign answerHere = pendValid && (pendTid == tid_t'(t));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hazCnt <= '0;
      end else if (issuedHere) begin
        hazCnt <= hazDist[t*HAZ_W +: HAZ_W];
      end else if (hazCnt != '0) begin
        hazCnt <= hazCnt - 1'b1;
      end
    end

    // wake has priority over a refusal in the same cycle
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        parked <= 1'b0;
      end else if (wake[t]) begin
        parked <= 1'b0;
      end else if (answerHere && !lockGrant) begin
        parked <= 1'b1;
      end
    end

    assign elig[t] = threadReady[t] && !parked && (hazCnt == '0) && !answerHere;

    // R4: a nonzero distance keeps the thread out of the next cycle
    p_haz_hold_r4 : assert property (@(posedge clk) disable iff (!rstN)
      issuedHere && (hazDist[t*HAZ_W +: HAZ_W] != '0) |=> !elig[t]);

    // R6: no issue in the cycle the lock answer is due
    p_lock_hold_r6 : assert property (@(posedge clk) disable iff (!rstN)
      issuedHere && lockReq[t] |=> !elig[t]);

    // R7: refused without wake means out in the next cycle
    p_deny_park_r7 : assert property (@(posedge clk) disable iff (!rstN)
      answerHere && !lockGrant && !wake[t] |=> !elig[t]);
  end
endmodule

// File: rtl/sched_pick.sv
module sched_pick
  import sched_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [THREADS-1:0] elig,
  output issue_strobe_t      strobe
);
  tid_t rrPtr;
  tid_t pick;
  logic found;

  function automatic tid_t nextOf(tid_t x);
    return (int'(x) == THREADS - 1) ? tid_t'(0) : tid_t'(int'(x) + 1);
  endfunction

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < THREADS; k++) begin
      tid_t idx;
      idx = tid_t'((int'(rrPtr) + k) % THREADS);
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

  assign strobe.fire = found && rstN;
  assign strobe.tid  = pick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobe.fire) begin
      rrPtr <= nextOf(pick);
    end
  end

  // R2: only an eligible thread is issued
  p_pick_elig_r2 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> elig[strobe.tid]);

  // R2: never a bubble while some thread qualifies
  p_no_idle_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (|elig) |-> strobe.fire);

  // R3: the successor of the last issued thread wins when eligible
  p_rr_next_r3 : assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.fire) && elig[nextOf($past(strobe.tid))]
      |-> strobe.fire && (strobe.tid == nextOf($past(strobe.tid))));
endmodule

// File: rtl/lock_aware_sched.sv
module lock_aware_sched
  import sched_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [THREADS-1:0]        threadReady,
  input  logic [THREADS*HAZ_W-1:0]  hazDist,
  input  logic [THREADS-1:0]        lockReq,
  input  logic                      lockGrant,
  input  logic [THREADS-1:0]        wake,
  output logic                      issueValid,
  output logic [TID_W-1:0]          issueTid
);
  logic [THREADS-1:0] elig;
  issue_strobe_t      strobe;

  sched_state i_state (
    .clk         (clk),
    .rstN        (rstN),
    .threadReady (threadReady),
    .hazDist     (hazDist),
    .lockReq     (lockReq),
    .lockGrant   (lockGrant),
    .wake        (wake),
    .strobe      (strobe),
    .elig        (elig)
  );

  sched_pick i_pick (
    .clk    (clk),
    .rstN   (rstN),
    .elig   (elig),
    .strobe (strobe)
  );

  assign issueValid = strobe.fire;
  assign issueTid   = strobe.tid;
endmodule

// File: tb/test_lock_aware_sched.sv
module test_lock_aware_sched;
  import sched_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  threadReady = '0;
  logic [7:0]  hazDist = '0;
  logic [3:0]  lockReq = '0;
  logic        lockGrant = 1'b0;
  logic [3:0]  wake = '0;
  logic        issueValid;
  logic [1:0]  issueTid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lock_aware_sched i_lock_aware_sched (
    .clk(clk), .rstN(rstN), .threadReady(threadReady), .hazDist(hazDist),
    .lockReq(lockReq), .lockGrant(lockGrant), .wake(wake),
    .issueValid(issueValid), .issueTid(issueTid)
  );

  // {req, ready, hazDist, lockReq, lockGrant, wake, expValid, expTid}
  localparam int NV = 32;
  localparam logic [27:0] VEC [NV] = '{
    28'b0001_1111_00000000_0000_0_0000_1_00, // R1 thread 0 first
    28'b0001_1111_00000000_0000_0_0000_1_01, // R1
    28'b0001_1111_00000000_0000_0_0000_1_10, // R1
    28'b0001_1111_00000000_0000_0_0000_1_11, // R1
    28'b0011_1111_00000000_0000_0_0000_1_00, // R3 wrap
    28'b0010_0000_00000000_0000_0_0000_0_00, // R2 bubble
    28'b0101_1001_00000000_0000_0_0000_1_11, // R5 skip unready
    28'b0011_1001_00000000_0000_0_0000_1_00, // R3
    28'b0100_1111_00001000_0000_0_0000_1_01, // R4 t1 distance 2
    28'b0100_0010_00000000_0000_0_0000_0_00, // R4 held
    28'b0100_0010_00000000_0000_0_0000_0_00, // R4 held
    28'b0100_0010_00000000_0000_0_0000_1_01, // R4 free again
    28'b1001_0100_00000000_0000_0_0000_1_10, // R9 cycle 0
    28'b1001_0100_00010000_0000_0_0000_1_10, // R9 cycle 1
    28'b1001_0100_00000000_0000_0_0000_0_00, // R9 gap
    28'b1001_0100_00000000_0000_0_0000_1_10, // R9 cycle 3
    28'b1001_0100_00000000_0000_0_0000_1_10, // R9 cycle 4
    28'b0110_1111_00000000_1000_0_0000_1_11, // R6 t3 lock issue
    28'b0110_1000_00000000_0000_0_0000_0_00, // R6 answer cycle, refused
    28'b0111_1000_00000000_0000_0_0000_0_00, // R7 parked
    28'b0111_1000_00000000_0000_0_0000_0_00, // R7 parked
    28'b0111_1000_00000000_0000_0_1000_0_00, // R7 wake pulse
    28'b0111_1000_00000000_0000_0_0000_1_11, // R7 replay
    28'b0110_0001_00000000_0001_0_0000_1_00, // R6 t0 lock issue
    28'b0110_0001_00000000_0000_1_0000_0_00, // R6 granted
    28'b0110_0001_00000000_0000_0_0000_1_00, // R6 runs on
    28'b1000_0010_00000000_0010_0_0000_1_01, // R8 t1 lock issue
    28'b1000_0010_00000000_0000_0_0010_0_00, // R8 refusal with wake
    28'b1000_0010_00000000_0000_0_0000_1_01, // R8 not parked
    28'b0110_1111_00000000_0100_0_0000_1_10, // R6 t2 lock issue
    28'b0110_0101_00000000_0000_1_0000_1_00, // R6 other thread runs
    28'b0110_0100_00000000_0000_0_0000_1_10  // R6 t2 after grant
  };

  task automatic check(input int req, input logic expV, input logic [1:0] expT);
    checks++;
    if (issueValid !== expV || (expV && issueTid !== expT)) begin
      errors++;
      $display("FAIL R%0d: valid=%0b tid=%0d expected valid=%0b tid=%0d",
               req, issueValid, issueTid, expV, expT);
    end
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: no issue while reset is held, even with all threads ready
    threadReady = 4'b1111;
    @(negedge clk); #1;
    check(1, 1'b0, 2'd0);
    threadReady = 4'b0000;
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      @(negedge clk);
      threadReady = v[23:20];
      hazDist     = v[19:12];
      lockReq     = v[11:8];
      lockGrant   = v[7];
      wake        = v[6:3];
      #1;
      check(int'(v[27:24]), v[2], v[1:0]);
    end

    // R10: same-cycle response to threadReady
    @(negedge clk);
    threadReady = 4'b0000; hazDist = '0; lockReq = '0; lockGrant = 1'b0; wake = '0;
    #0.5;
    check(10, 1'b0, 2'd0);
    threadReady = 4'b0001;
    #0.5;
    check(10, 1'b1, 2'd0);

    // R1: reset puts the pointer back to thread 0 (it would be 1 otherwise)
    @(negedge clk);
    threadReady = 4'b0000;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    threadReady = 4'b1111;
    #1;
    check(1, 1'b1, 2'd0);
    @(negedge clk); #1;
    check(1, 1'b1, 2'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule